// File: doc/BRIEF.md
# Supply-Monitor Interrupt/Reset Controller

This block watches a digital comparator output that reports whether the supply rail sits above a threshold. It produces a one-cycle interrupt, or a one-cycle request to the chip reset sequencer, when the rail crosses that threshold. The comparator level can be taken raw or through a digital filter. The filter samples on ticks of a low-speed oscillator, divided by a programmable ratio. The comparator and oscillator inputs are asynchronous, and each is brought into the system clock domain through a two-flop synchronizer.

Software controls the block through one 8-bit register, and a write lands only while an external unlock input is high. The register holds two sticky event flags: one for threshold crossings and one for watchdog detections. Only power-on reset clears these flags. A pulse on the secondary reset input clears every other field. A wake path for low-power stop mode must be rearmed by software after each wake.

Top module: `supply_monitor_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `rd_data` reads 8'h00 and `irq`, `rst_req` and `stop_wake` are 0.
- R2: A write (`wr_en`=1) updates the register, visible on the next cycle, only when `wr_unlock`=1. With `wr_unlock`=0 the register keeps its value. Field positions: [0] enable, [1] filter bypass, [2] crossing flag, [3] watchdog flag, [5:4] divider select, [6] mode (1 = reset), [7] direction (1 = falling).
- R3: The crossing flag [2] sets when the selected level changes while `det_enable`=1. A write of 0 to it clears it, and a write of 1 leaves it unchanged. If a set and a clear occur in the same cycle, the set wins.
- R4: A `wdt_detect` pulse sets flag [3]. A write of 0 to that bit clears it.
- R5: A `sys_rst` pulse clears bits [7:4] and [1:0] and leaves [3:2] unchanged.
- R6: The filter takes one sample every 1, 2, 4 or 8 oscillator rising edges, for divider select 0, 1, 2 or 3.
- R7: The filtered level takes a new value only when two consecutive samples agree on it. A low pulse that is seen by only one sample is dropped.
- R8: Interrupt mode ([6]=0) requires [0]=1 and `det_enable`=1. With the filter bypassed, only rising edges count when [7]=0, and only falling edges count when [7]=1. With the filter in use, every change of the filtered level counts. Each event gives a one-cycle `irq` pulse.
- R9: Reset mode ([6]=1) raises a one-cycle `rst_req` pulse only on a falling level, whatever [7] holds, and raises no `irq`.
- R10: No `irq` or `rst_req` pulse is raised while [0]=0 or `det_enable`=0.
- R11: While `in_stop`=1, an interrupt event also pulses `stop_wake`, but only if bit [1] has been written from 0 to 1 since the last wake. A wake, a write of 0 to [1], or `sys_rst` disarms the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst | input | 1 | Secondary reset pulse (software, watchdog or monitor) |
| wr_en | input | 1 | Register write strobe |
| wr_unlock | input | 1 | Write protection release |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents |
| det_enable | input | 1 | Detection circuit enabled |
| cmp_async | input | 1 | Comparator output, 1 = supply above threshold |
| osc_async | input | 1 | Low-speed oscillator clock, sampled as data |
| wdt_detect | input | 1 | Watchdog detection pulse |
| in_stop | input | 1 | Chip is in low-power stop mode |
| irq | output | 1 | Interrupt pulse |
| rst_req | output | 1 | Reset request pulse |
| stop_wake | output | 1 | Stop-mode wake pulse |

## Verification
The hardest state to reach from the ports is the filter's choice between accepting and dropping a pulse. That choice depends on the phase of the free-running oscillator divider against the comparator stimulus. The bench keeps the oscillator running for the whole test. It picks pulse widths that fall cleanly on one side of the threshold at each ratio: wider than three sample periods to pass, shorter than one to be dropped. Its cycle model then tracks the exact phase on every clock. A second such state is the stop-wake path after a wake has consumed it. The bench drives the 0-then-1 write sequence on the bypass bit and confirms that only the rearmed event wakes.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int SEL_W = 2;
  localparam int CNT_W = (1 << SEL_W) - 1;

  typedef struct packed {
    logic             cond_fall;
    logic             rst_mode;
    logic [SEL_W-1:0] div_sel;
    logic             wdt_flag;
    logic             cross_flag;
    logic             filt_off;
    logic             enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Last count value of the sample divider: 2**sel - 1.
  function automatic logic [CNT_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] v;
    v = '0;
    for (int i = 0; i < CNT_W; i++)
      if (i < int'(sel)) v[i] = 1'b1;
    return v;
  endfunction

  // Filter step: take the new sample only when it matches the previous one.
  function automatic logic filt_step(input logic held, input logic prev_s, input logic new_s);
    return (prev_s == new_s) ? new_s : held;
  endfunction

  // Interrupt qualification from the level edges.
  function automatic logic irq_hit(input logic bypass, input logic fall_sel,
                                   input logic up, input logic dn);
    if (bypass) return fall_sel ? dn : up;
    return up | dn;
  endfunction
endpackage

// File: rtl/sm_sync.sv
module sm_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sm_sample_div.sv
module sm_sample_div
  import sm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_lvl,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  logic             osc_d;
  logic [CNT_W-1:0] cnt;
  logic             osc_rise;

  assign osc_rise = osc_lvl & ~osc_d;
  assign tick     = osc_rise && (cnt >= div_last(div_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_d <= 1'b0;
      cnt   <= '0;
    end else begin
      osc_d <= osc_lvl;
      if (osc_rise) cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sm_filter.sv
module sm_filter
  import sm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic lvl
);
  logic samp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp <= 1'b1;
      lvl  <= 1'b1;
    end else if (tick) begin
      samp <= din;
      lvl  <= filt_step(lvl, samp, din);
    end
  end
endmodule

// File: rtl/supply_monitor_ctrl.sv
module supply_monitor_ctrl
  import sm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       wr_en,
  input  logic       wr_unlock,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       det_enable,
  input  logic       cmp_async,
  input  logic       osc_async,
  input  logic       wdt_detect,
  input  logic       in_stop,
  output logic       irq,
  output logic       rst_req,
  output logic       stop_wake
);
  ctrl_t cr, cr_nxt, wd;
  logic  cmp_s, osc_s, sample_tick, filt_lvl;
  logic  raw_d, filt_d;
  logic  up, dn, wr_ok, armed, irq_evt, rst_evt, wake_evt, cross_set;
  logic  wake_arm;

  sm_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({osc_async, cmp_async}), .q({osc_s, cmp_s}));

  sm_sample_div u_div (
    .clk(clk), .rst_n(rst_n), .osc_lvl(osc_s), .div_sel(cr.div_sel), .tick(sample_tick));

  sm_filter u_filt (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .din(cmp_s), .lvl(filt_lvl));

  assign wd      = ctrl_t'(wr_data);
  assign wr_ok   = wr_en & wr_unlock;
  assign up      = cr.filt_off ? (cmp_s & ~raw_d) : (filt_lvl & ~filt_d);
  assign dn      = cr.filt_off ? (~cmp_s & raw_d) : (~filt_lvl & filt_d);
  assign armed   = det_enable & cr.enable;
  assign irq_evt = armed & ~cr.rst_mode & irq_hit(cr.filt_off, cr.cond_fall, up, dn);
  assign rst_evt = armed & cr.rst_mode & dn;
  assign wake_evt  = in_stop & wake_arm & irq_evt;
  assign cross_set = det_enable & (up | dn);

  always_comb begin
    cr_nxt = cr;
    if (wr_ok) begin
      cr_nxt.enable    = wd.enable;
      cr_nxt.filt_off  = wd.filt_off;
      cr_nxt.div_sel   = wd.div_sel;
      cr_nxt.rst_mode  = wd.rst_mode;
      cr_nxt.cond_fall = wd.cond_fall;
      if (!wd.cross_flag) cr_nxt.cross_flag = 1'b0;
      if (!wd.wdt_flag)   cr_nxt.wdt_flag   = 1'b0;
    end
    if (sys_rst) begin
      cr_nxt.enable    = 1'b0;
      cr_nxt.filt_off  = 1'b0;
      cr_nxt.div_sel   = '0;
      cr_nxt.rst_mode  = 1'b0;
      cr_nxt.cond_fall = 1'b0;
    end
    if (cross_set)  cr_nxt.cross_flag = 1'b1;
    if (wdt_detect) cr_nxt.wdt_flag   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr        <= '0;
      raw_d     <= 1'b1;
      filt_d    <= 1'b1;
      wake_arm  <= 1'b0;
      irq       <= 1'b0;
      rst_req   <= 1'b0;
      stop_wake <= 1'b0;
    end else begin
      cr        <= cr_nxt;
      raw_d     <= cmp_s;
      filt_d    <= filt_lvl;
      irq       <= irq_evt;
      rst_req   <= rst_evt;
      stop_wake <= wake_evt;
      if (sys_rst)                            wake_arm <= 1'b0;
      else if (wr_ok && !wd.filt_off)         wake_arm <= 1'b0;
      else if (wr_ok && !cr.filt_off)         wake_arm <= 1'b1;
      else if (wake_evt)                      wake_arm <= 1'b0;
    end
  end

  assign rd_data = cr;
endmodule

// File: rtl/sm_ctrl_checker.sv
module sm_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst,
  input logic       wr_en,
  input logic       wr_unlock,
  input logic [7:0] wr_data,
  input logic       det_enable,
  input logic       wdt_detect,
  input logic       in_stop,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       rst_req,
  input logic       stop_wake,
  input logic       sample_tick,
  input logic       filt_lvl
);
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_unlock && !sys_rst) |=>
      (rd_data[7:4] == $past(rd_data[7:4]) && rd_data[1:0] == $past(rd_data[1:0]))); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2] && !(wr_en && wr_unlock && !wr_data[2])) |=> rd_data[2]); // R3
  AST_WDT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_detect |=> rd_data[3]); // R4
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (rd_data[7:4] == 4'h0 && rd_data[1:0] == 2'b00)); // R5
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick); // R6
  AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> $past(sample_tick)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && rst_req)); // R9
  AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || rst_req) |-> ($past(det_enable) && $past(rd_data[0]))); // R10
  AST_WAKE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wake |-> ($past(in_stop) && irq)); // R11
endmodule

bind supply_monitor_ctrl sm_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wr_en(wr_en), .wr_unlock(wr_unlock),
  .wr_data(wr_data), .det_enable(det_enable), .wdt_detect(wdt_detect), .in_stop(in_stop),
  .rd_data(rd_data), .irq(irq), .rst_req(rst_req), .stop_wake(stop_wake),
  .sample_tick(sample_tick), .filt_lvl(filt_lvl));

// File: tb/test_supply_monitor_ctrl.sv
`timescale 1ns/1ps
module test_supply_monitor_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, sys_rst = 1'b0, wr_en = 1'b0, wr_unlock = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic det_enable = 1'b0, cmp_async = 1'b1, osc_async = 1'b0, wdt_detect = 1'b0, in_stop = 1'b0;
  logic irq, rst_req, stop_wake;

  supply_monitor_ctrl i_supply_monitor_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wr_en(wr_en), .wr_unlock(wr_unlock),
    .wr_data(wr_data), .rd_data(rd_data), .det_enable(det_enable), .cmp_async(cmp_async),
    .osc_async(osc_async), .wdt_detect(wdt_detect), .in_stop(in_stop),
    .irq(irq), .rst_req(rst_req), .stop_wake(stop_wake));

  int checks = 0, fails = 0;
  int n_irq = 0, n_rst = 0, n_wake = 0, cycles = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Free-running oscillator: toggles every 3 system cycles.
  initial forever begin
    repeat (3) @(negedge clk);
    osc_async = ~osc_async;
  end

  // Behavioural reference model.
  logic c1, c2, o1, o2, o3, samp, filt, rawp, filtp, arm, e_irq, e_rst, e_wake;
  logic [7:0] m_reg;
  int cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 = 1; c2 = 1; o1 = 0; o2 = 0; o3 = 0; samp = 1; filt = 1; rawp = 1; filtp = 1;
      arm = 0; e_irq = 0; e_rst = 0; e_wake = 0; m_reg = 8'h00; cnt = 0;
    end else begin
      logic rise_o, tick, up, dn, live, hi, hr, hw, nf;
      logic [7:0] nreg;
      int lim;
      rise_o = o2 && !o3;
      lim = (1 << m_reg[5:4]) - 1;
      tick = rise_o && (cnt >= lim);
      up = m_reg[1] ? (c2 && !rawp) : (filt && !filtp);
      dn = m_reg[1] ? (!c2 && rawp) : (!filt && filtp);
      live = det_enable && m_reg[0];
      hi = live && !m_reg[6] && (m_reg[1] ? (m_reg[7] ? dn : up) : (up || dn));
      hr = live && m_reg[6] && dn;
      hw = in_stop && arm && hi;
      nreg = m_reg;
      if (wr_en && wr_unlock) begin
        nreg = (wr_data & 8'hF3) | (m_reg & 8'h0C);
        if (!wr_data[2]) nreg[2] = 1'b0;
        if (!wr_data[3]) nreg[3] = 1'b0;
      end
      if (sys_rst) nreg = nreg & 8'h0C;
      if (det_enable && (up || dn)) nreg[2] = 1'b1;
      if (wdt_detect) nreg[3] = 1'b1;
      if (sys_rst) arm = 0;
      else if (wr_en && wr_unlock && !wr_data[1]) arm = 0;
      else if (wr_en && wr_unlock && !m_reg[1]) arm = 1;
      else if (hw) arm = 0;
      nf = filt;
      if (tick) begin
        if (c2 == samp) nf = c2;
        samp = c2;
      end
      filtp = filt; filt = nf;
      rawp = c2; c2 = c1; c1 = cmp_async;
      o3 = o2; o2 = o1; o1 = osc_async;
      if (rise_o) cnt = tick ? 0 : cnt + 1;
      m_reg = nreg; e_irq = hi; e_rst = hr; e_wake = hw;
    end
  end

  // Per-cycle comparison against the model and pulse counting.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 rd_data vs model", rd_data, m_reg);
      chk("R8 irq vs model", irq, e_irq);
      chk("R9 rst_req vs model", rst_req, e_rst);
      chk("R11 stop_wake vs model", stop_wake, e_wake);
      if (irq) n_irq++;
      if (rst_req) n_rst++;
      if (stop_wake) n_wake++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic write_reg(input logic [7:0] v, input logic unlock);
    wr_en = 1'b1; wr_data = v; wr_unlock = unlock;
    step(1);
    wr_en = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic pulse_low(input int width);
    cmp_async = 1'b0; step(width);
    cmp_async = 1'b1;
  endtask

  int base;
  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset outputs", {irq, rst_req, stop_wake}, 0);

    write_reg(8'hFF, 1'b0);
    chk("R2 locked write ignored", rd_data, 8'h00);
    write_reg(8'h03, 1'b1);
    chk("R2 unlocked write", rd_data, 8'h03);

    det_enable = 1'b1;
    pulse_low(10); step(10);
    chk("R8 rising-only count", n_irq, 1);
    chk("R3 flag set on crossing", rd_data[2], 1);
    write_reg(8'h07, 1'b1);
    chk("R3 write one keeps flag", rd_data[2], 1);
    write_reg(8'h03, 1'b1);
    chk("R3 write zero clears flag", rd_data[2], 0);

    write_reg(8'h83, 1'b1);
    base = n_irq;
    cmp_async = 1'b0; step(10);
    chk("R8 falling edge fires", n_irq, base + 1);
    cmp_async = 1'b1; step(10);
    chk("R8 rising edge ignored", n_irq, base + 1);

    write_reg(8'h83, 1'b1);
    det_enable = 1'b0;
    base = n_irq;
    pulse_low(10); step(10);
    chk("R10 no irq when detection disabled", n_irq, base);
    chk("R3 no flag when detection disabled", rd_data[2], 0);
    det_enable = 1'b1;

    write_reg(8'h43, 1'b1);
    base = n_irq;
    cmp_async = 1'b0; step(10);
    chk("R9 reset request on fall", n_rst, 1);
    cmp_async = 1'b1; step(10);
    chk("R9 no request on rise", n_rst, 1);
    chk("R9 no irq in reset mode", n_irq, base);

    wdt_detect = 1'b1; step(1); wdt_detect = 1'b0;
    chk("R4 watchdog flag set", rd_data[3], 1);
    sys_rst = 1'b1; step(1); sys_rst = 1'b0;
    chk("R5 secondary reset keeps flags", rd_data, 8'h0C);
    write_reg(8'h04, 1'b1);
    chk("R4 write zero clears watchdog flag", rd_data, 8'h04);

    step(60);
    write_reg(8'h31, 1'b1);
    base = n_irq;
    pulse_low(20); step(120);
    chk("R6 divide-by-8 drops 20-cycle pulse", n_irq, base);
    write_reg(8'h01, 1'b1);
    pulse_low(4); step(30);
    chk("R7 single-sample pulse dropped", n_irq, base);
    pulse_low(30); step(40);
    chk("R7 long pulse passes both edges", n_irq, base + 2);

    in_stop = 1'b1;
    write_reg(8'h03, 1'b1);
    pulse_low(10); step(10);
    chk("R11 armed wake", n_wake, 1);
    pulse_low(10); step(10);
    chk("R11 no wake before rearm", n_wake, 1);
    write_reg(8'h01, 1'b1);
    write_reg(8'h03, 1'b1);
    pulse_low(10); step(10);
    chk("R11 wake after rearm", n_wake, 2);
    in_stop = 1'b0;

    step(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule